// File: doc/BRIEF.md
# Fully Associative LRU Read Cache with Victim Buffer

This block is a small read-only cache. Its main store is fully associative, so a line with any tag may sit in any entry, and it picks a replacement slot by true least-recently-used order. Each main entry keeps an age counter. Age 0 marks the entry used most recently. The ages of the entries always form a permutation of 0 to MAIN_N-1.

A line pushed out of the main store is not dropped. It moves into a small victim buffer. Each lookup compares its tag against the main store and the victim buffer in the same cycle:

- **Main hit:** the block returns the data and updates the ages.
- **Victim hit:** the line swaps back into the main store with no memory access, and the line it displaces takes the freed victim slot.
- **Miss in both:** the block raises a fill request on a simple valid/ready request port and waits for a one-beat response. It then installs the line and returns the data.

The client presents a tag with `lk_valid` while `lk_ready` is high. The block does not accept a new lookup while a fill is outstanding.

Top module: `lru_victim_cache`

## Requirements
- R1: After reset `lk_ready` is 1, `rd_valid` is 0, `mem_req_valid` is 0, and no entry of either store is valid, so the first lookup of any tag misses.
- R2: Any tag can occupy any main entry, and empty main entries are filled before any valid line is replaced. Eight distinct tags looked up after reset all miss once and then all hit in the main store.
- R3: A lookup accepted on a clock edge that hits the main store produces `rd_valid`=1 one cycle later, with `rd_kind`=2'b01 and the stored data, and it issues no memory request.
- R4: On each main-store access, the touched entry's age becomes 0 and every entry younger than its old age ages by one. A replacement takes the entry with the highest age (MAIN_N-1).
- R5: A valid line displaced from the main store by a fill is written into the victim buffer and stays retrievable.
- R6: A lookup that hits the victim buffer returns its data with the same one-cycle latency as a main hit, with `rd_kind`=2'b10. It issues no memory request. The line moves into the main store's replacement slot, and the line that was there moves into the freed victim slot.
- R7: On a miss, `mem_req_valid` rises one cycle after acceptance with `mem_req_tag` equal to the looked-up tag. Both are held unchanged until a cycle with `mem_req_ready`=1, after which `mem_req_valid` drops.
- R8: On the edge where `mem_rsp_valid`=1 while a response is awaited, the line is installed. One cycle later `rd_valid`=1, `rd_kind`=2'b00 and `rd_data` equals `mem_rsp_data`. A later lookup of that tag is a main hit.
- R9: The victim buffer writes displaced lines into its slots in round-robin FIFO order. A fifth capture overwrites the slot written first, even if a swap has since refreshed that slot.
- R10: `lk_ready` is 0 from the cycle after a missing lookup is accepted until the fill completes. A lookup driven in that window is ignored and produces no `rd_valid`.
- R11: A tag is never valid in the main store and the victim buffer at the same time, nor in two main entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to look up |
| lk_ready | output | 1 | Block can accept a lookup |
| rd_valid | output | 1 | Read result valid for one cycle |
| rd_kind | output | 2 | 00 filled from memory, 01 main hit, 10 victim hit |
| rd_data | output | DATA_W | Returned line data |
| mem_req_valid | output | 1 | Fill request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_tag | output | TAG_W | Tag to fetch |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_data | input | DATA_W | Fill data |

## Verification
The bench first runs a cold sequence of eight distinct tags and then runs the same tags warm. This separates empty-slot filling from replacement and shows main hits needing no memory traffic. A touch in the middle of the order, followed by two new misses, shows that eviction follows the age order rather than slot or insertion order. Lookups of just-evicted tags separate victim hits from main hits and full misses, and a follow-up access shows where each swapped line ended up. A run of misses that overflows the victim buffer separates FIFO overwrite from recency-based overwrite. A held-off request with a lookup attempted during the fill shows the request is held stable and the busy window blocks lookups.

// File: rtl/lvc_pkg.sv
package lvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lvc_state_e;

  localparam logic [1:0] KIND_FILL = 2'b00;
  localparam logic [1:0] KIND_MAIN = 2'b01;
  localparam logic [1:0] KIND_VICT = 2'b10;
endpackage

// File: rtl/lvc_match.sv
module lvc_match #(
  parameter int N     = 8,
  parameter int TAG_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lvc_age.sv
module lvc_age #(
  parameter int N     = 8,
  parameter int AGE_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    touch,
  input  logic [AGE_W-1:0]        touch_idx,
  input  logic [N-1:0]            valid,
  output logic [AGE_W-1:0]        repl_idx,
  output logic [N-1:0][AGE_W-1:0] ages
);
  logic [AGE_W-1:0] old_age;

  assign old_age = ages[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ages[i] <= AGE_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (AGE_W'(i) == touch_idx) ages[i] <= '0;
        else if (ages[i] < old_age) ages[i] <= ages[i] + 1'b1;
      end
    end
  end

  always_comb begin
    repl_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ages[i] == AGE_W'(N - 1)) repl_idx = AGE_W'(i);
    end
    if (!(&valid)) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!valid[i]) repl_idx = AGE_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_victim_cache.sv
module lru_victim_cache
  import lvc_pkg::*;
#(
  parameter int MAIN_N = 8,
  parameter int VICT_N = 4,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic              rd_valid,
  output logic [1:0]        rd_kind,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int MI_W = $clog2(MAIN_N);
  localparam int VI_W = $clog2(VICT_N);

  lvc_state_e st;

  logic [MAIN_N-1:0]              m_valid;
  logic [MAIN_N-1:0][TAG_W-1:0]   m_tag;
  logic [MAIN_N-1:0][DATA_W-1:0]  m_data;
  logic [VICT_N-1:0]              v_valid;
  logic [VICT_N-1:0][TAG_W-1:0]   v_tag;
  logic [VICT_N-1:0][DATA_W-1:0]  v_data;
  logic [VI_W-1:0]                v_wp;
  logic [TAG_W-1:0]               req_tag;

  logic                   m_hit, v_hit;
  logic [MI_W-1:0]        m_idx, slot;
  logic [VI_W-1:0]        v_idx;
  logic [MAIN_N-1:0][MI_W-1:0] age_q;
  logic accept, do_mhit, do_vhit, do_fill, touch;
  logic [MI_W-1:0] touch_idx;

  lvc_match #(.N(MAIN_N), .TAG_W(TAG_W), .IDX_W(MI_W)) i_mmatch (
    .valid(m_valid), .tags(m_tag), .key(lk_tag), .hit(m_hit), .idx(m_idx)
  );

  lvc_match #(.N(VICT_N), .TAG_W(TAG_W), .IDX_W(VI_W)) i_vmatch (
    .valid(v_valid), .tags(v_tag), .key(lk_tag), .hit(v_hit), .idx(v_idx)
  );

  lvc_age #(.N(MAIN_N), .AGE_W(MI_W)) i_age (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid(m_valid), .repl_idx(slot), .ages(age_q)
  );

  assign lk_ready      = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_tag   = req_tag;

  assign accept    = lk_valid && lk_ready;
  assign do_mhit   = accept && m_hit;
  assign do_vhit   = accept && !m_hit && v_hit;
  assign do_fill   = (st == ST_WAIT) && mem_rsp_valid;
  assign touch     = do_mhit || do_vhit || do_fill;
  assign touch_idx = do_mhit ? m_idx : slot;

  // control, valid bits and tags
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      m_valid  <= '0;
      v_valid  <= '0;
      v_wp     <= '0;
      rd_valid <= 1'b0;
      rd_kind  <= KIND_FILL;
      req_tag  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (do_mhit) begin
            rd_valid <= 1'b1;
            rd_kind  <= KIND_MAIN;
          end else if (do_vhit) begin
            rd_valid       <= 1'b1;
            rd_kind        <= KIND_VICT;
            m_valid[slot]  <= 1'b1;
            m_tag[slot]    <= v_tag[v_idx];
            v_valid[v_idx] <= m_valid[slot];
            v_tag[v_idx]   <= m_tag[slot];
          end else if (accept) begin
            st      <= ST_REQ;
            req_tag <= lk_tag;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rd_valid      <= 1'b1;
            rd_kind       <= KIND_FILL;
            m_valid[slot] <= 1'b1;
            m_tag[slot]   <= req_tag;
            if (m_valid[slot]) begin
              v_valid[v_wp] <= 1'b1;
              v_tag[v_wp]   <= m_tag[slot];
              v_wp <= (v_wp == VI_W'(VICT_N - 1)) ? '0 : v_wp + 1'b1;
            end
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // data arrays and read data: no reset, plain indexed writes
  always_ff @(posedge clk) begin
    if (do_mhit) rd_data <= m_data[m_idx];
    if (do_vhit) begin
      rd_data        <= v_data[v_idx];
      m_data[slot]   <= v_data[v_idx];
      v_data[v_idx]  <= m_data[slot];
    end
    if (do_fill) begin
      rd_data      <= mem_rsp_data;
      m_data[slot] <= mem_rsp_data;
      if (m_valid[slot]) v_data[v_wp] <= m_data[slot];
    end
  end
endmodule

// File: rtl/lvc_chk.sv
module lvc_chk #(
  parameter int MAIN_N = 8,
  parameter int VICT_N = 4,
  parameter int TAG_W  = 16,
  parameter int MI_W   = $clog2(MAIN_N)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         lk_ready,
  input logic                         rd_valid,
  input logic [1:0]                   rd_kind,
  input logic                         mem_req_valid,
  input logic                         mem_req_ready,
  input logic [TAG_W-1:0]             mem_req_tag,
  input logic                         do_mhit,
  input logic                         do_vhit,
  input logic [MAIN_N-1:0]            m_valid,
  input logic [MAIN_N-1:0][TAG_W-1:0] m_tag,
  input logic [VICT_N-1:0]            v_valid,
  input logic [VICT_N-1:0][TAG_W-1:0] v_tag,
  input logic [MAIN_N-1:0][MI_W-1:0]  age_q
);
  logic [MAIN_N-1:0] seen;
  logic dup;

  always_comb begin
    seen = '0;
    for (int i = 0; i < MAIN_N; i++) seen[age_q[i]] = 1'b1;
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < MAIN_N; i++) begin
      for (int j = i + 1; j < MAIN_N; j++)
        if (m_valid[i] && m_valid[j] && m_tag[i] == m_tag[j]) dup = 1'b1;
      for (int k = 0; k < VICT_N; k++)
        if (m_valid[i] && v_valid[k] && m_tag[i] == v_tag[k]) dup = 1'b1;
    end
  end

  AST_MAIN_HIT_RESULT: assert property (@(posedge clk) disable iff (rst)
    do_mhit |=> rd_valid && rd_kind == 2'b01 && !mem_req_valid);          // R3
  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
    &seen);                                                              // R4
  AST_VICTIM_HIT_RESULT: assert property (@(posedge clk) disable iff (rst)
    do_vhit |=> rd_valid && rd_kind == 2'b10 && !mem_req_valid);          // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_tag)); // R7
  AST_BUSY_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !lk_ready);                                        // R10
  AST_NO_DUPLICATE_LINE: assert property (@(posedge clk) disable iff (rst)
    !dup);                                                               // R11
endmodule

bind lru_victim_cache lvc_chk #(
  .MAIN_N(MAIN_N), .VICT_N(VICT_N), .TAG_W(TAG_W)
) i_chk (
  .clk(clk), .rst(rst), .lk_ready(lk_ready), .rd_valid(rd_valid),
  .rd_kind(rd_kind), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_tag(mem_req_tag),
  .do_mhit(do_mhit), .do_vhit(do_vhit), .m_valid(m_valid), .m_tag(m_tag),
  .v_valid(v_valid), .v_tag(v_tag), .age_q(age_q)
);

// File: tb/test_lru_victim_cache.sv
`timescale 1ns/1ps
module test_lru_victim_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_tag = '0;
  logic        lk_ready, rd_valid, mem_req_valid;
  logic [1:0]  rd_kind;
  logic [31:0] rd_data;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_tag;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_run = 0;
  int n_fail = 0;
  int n_req = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lru_victim_cache i_lru_victim_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .lk_ready(lk_ready), .rd_valid(rd_valid), .rd_kind(rd_kind),
    .rd_data(rd_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (mem_req_valid && mem_req_ready) n_req++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] line_of(input logic [15:0] t);
    return {t ^ 16'h5A3C, ~t};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // One lookup; misses are served with the given wait cycles.
  task automatic lookup(input logic [15:0] t, input logic [1:0] kind,
                        input int req_wait, input int rsp_wait, input string rq);
    int reqs0;
    reqs0 = n_req;
    @(negedge clk);
    check(lk_ready == 1'b1, rq, "lk_ready before lookup", lk_ready, 1);
    lk_valid = 1'b1; lk_tag = t;
    @(negedge clk);
    lk_valid = 1'b0;
    if (kind != 2'b00) begin
      check(rd_valid == 1'b1, rq, "hit rd_valid", rd_valid, 1);
      check(rd_kind == kind, rq, "hit rd_kind", rd_kind, kind);
      check(rd_data == line_of(t), rq, "hit rd_data", rd_data, line_of(t));
      check(mem_req_valid == 1'b0 && n_req == reqs0, rq, "hit issued no request",
            n_req - reqs0, 0);
    end else begin
      check(rd_valid == 1'b0, rq, "miss no early rd_valid", rd_valid, 0);
      check(mem_req_valid == 1'b1, rq, "miss mem_req_valid", mem_req_valid, 1);
      check(mem_req_tag == t, rq, "miss mem_req_tag", mem_req_tag, t);
      for (int i = 0; i < req_wait; i++) begin
        lk_valid = 1'b1; lk_tag = t + 16'h100;  // R10: must be ignored
        @(negedge clk);
        check(mem_req_valid == 1'b1 && mem_req_tag == t, "R7", "request held",
              {mem_req_valid, mem_req_tag}, {1'b1, t});
        check(lk_ready == 1'b0 && rd_valid == 1'b0, "R10", "busy while requesting",
              {lk_ready, rd_valid}, 0);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(mem_req_valid == 1'b0, "R7", "request dropped after accept", mem_req_valid, 0);
      for (int i = 0; i < rsp_wait; i++) begin
        @(negedge clk);
        check(lk_ready == 1'b0 && rd_valid == 1'b0, "R10", "busy while waiting",
              {lk_ready, rd_valid}, 0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = line_of(t); lk_valid = 1'b0;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check(rd_valid == 1'b1 && rd_kind == 2'b00, rq, "fill result kind",
            {rd_valid, rd_kind}, {1'b1, 2'b00});
      check(rd_data == line_of(t), "R8", "fill rd_data", rd_data, line_of(t));
      check(n_req == reqs0 + 1, rq, "one request per miss", n_req - reqs0, 1);
    end
    @(negedge clk);
    check(rd_valid == 1'b0, rq, "single result pulse", rd_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(lk_ready == 1'b1, "R1", "reset lk_ready", lk_ready, 1);
    check(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_cold_fill();  // R1 first miss, R2, R8
    for (int i = 1; i <= 8; i++) lookup(16'(i), 2'b00, i % 3, i % 2, "R2");
  endtask

  task automatic t_warm_hits();  // R2 no eviction, R3
    for (int i = 1; i <= 8; i++) lookup(16'(i), 2'b01, 0, 0, "R3");
  endtask

  task automatic t_lru_evict();  // R4, R5, R6
    lookup(16'd3, 2'b01, 0, 0, "R4");
    lookup(16'd9, 2'b00, 0, 0, "R4");   // evicts 1
    lookup(16'd10, 2'b00, 1, 0, "R4");  // evicts 2 (3 kept by its touch)
    lookup(16'd3, 2'b01, 0, 0, "R4");
  endtask

  task automatic t_victim_swap();  // R5, R6, R11
    // order now oldest first: 4 5 6 7 8 9 10 3; victims: 1 2
    lookup(16'd1, 2'b10, 0, 0, "R5");   // swap with 4
    lookup(16'd4, 2'b10, 0, 0, "R6");   // displaced 4 kept; swap with 5
    lookup(16'd1, 2'b01, 0, 0, "R11");  // 1 now lives in main only
    lookup(16'd2, 2'b10, 0, 0, "R6");   // swap with 6
  endtask

  task automatic t_fifo();  // R9
    // main oldest first: 7 8 9 10 3 4 1 2; victim slots: 0=5 1=6
    lookup(16'd11, 2'b00, 0, 0, "R9");  // 7 -> slot2
    lookup(16'd12, 2'b00, 0, 0, "R9");  // 8 -> slot3
    lookup(16'd13, 2'b00, 0, 0, "R9");  // 9 -> slot0, 5 lost
    lookup(16'd5, 2'b00, 2, 3, "R9");   // full miss, 10 -> slot1
    lookup(16'd9, 2'b10, 0, 0, "R9");
    lookup(16'd7, 2'b10, 0, 0, "R9");
  endtask

  task automatic t_busy();  // R7, R10
    lookup(16'h0777, 2'b00, 4, 2, "R10");
    lookup(16'h0777, 2'b01, 0, 0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cold_fill();
    t_warm_hits();
    t_lru_evict();
    t_victim_swap();
    t_fifo();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule